// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Generator

This block runs one access at a time on an external static-memory bus that serves up to eight chip-select regions. Each region has its own 32-bit timing word, supplied on a flat configuration input. The word sets five things: the address lead and lag around CS, the CS lead and lag around the read or write strobe, the strobe width in wait states, the idle time needed after a read before the bus may be driven again, and how the 16-bit data path maps onto the devices behind that select.

A requester presents a region number, an address, a direction, write data and byte enables with a valid/ready handshake. The block then steps through these phases in order: address lead, CS lead, strobe, CS lag, address lag and float. It skips any phase whose length is zero. It drives CS, the read strobe, the per-lane write strobes, the byte selects, the address and the output data, all from flops. At the end of the strobe it returns the read data and a one-cycle done pulse. The timing word is sampled when the request is accepted and stays in force for the whole access.

Top module: `smc_cs_timing`

## Requirements
- R1: During and after synchronous reset, every CS, the read strobe, both write strobes and both byte selects are high (inactive). Output enable and done are low, and the ready output is high.
- R2: A request for region k uses bits [32k+31:32k] of `cfg_words` as its timing word. The only CS line driven low during the access is `mem_cs_n[k]`.
- R3: After acceptance, the address is on `mem_addr` for word bits 17:16 clocks with every CS high before CS falls. It stays unchanged while CS is low.
- R4: For writes, and for reads with bit 15 clear, CS is low for word bits 25:24 clocks before the strobe becomes active.
- R5: With bit 7 set, the strobe is active for (bits 6:0) + 1 clocks. With bit 7 clear, it is active for exactly one clock, whatever bits 6:0 hold.
- R6: After the strobe is released, CS stays low for word bits 29:28 clocks.
- R7: After CS rises, ready returns after (bits 17:16) + (bits 11:8) clocks for a read and after (bits 17:16) clocks for a write. Ready is never high while an access is in progress.
- R8: When bit 15 is set, a read strobe goes low in the same clock as CS, with no CS lead. Writes on that region keep the lead set by bits 25:24.
- R9: Read data is sampled from `mem_din` in the last strobe clock. `rsp_done` is high for exactly the one clock that follows the end of the strobe, for reads and for writes alike.
- R10: With bits 14:13 not equal to 2 and bit 12 clear (one 16-bit device), both write strobes go low together. `mem_bls_n` equals the inverted byte enables for as long as CS is low.
- R11: With bits 14:13 not equal to 2 and bit 12 set (two 8-bit devices), write strobe lane i goes low only if byte enable i is set. The byte selects stay high.
- R12: With bits 14:13 equal to 2 (8-bit bus), only write strobe lane 0 goes low, whatever the byte enables are. The byte selects stay high, and the upper byte of the returned read data is zero.
- R13: During a write, `mem_doe` is high and `mem_dout` holds the write data for exactly the clocks that CS is low. During a read, `mem_doe` stays low.
- R14: At most one CS is low at any time. Read and write strobes are never active together, and no strobe or output enable is active while every CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | NCS*32 | Timing word per region, region k at bits [32k+31:32k] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on a clock with valid and ready high |
| req_cs | input | clog2(NCS) | Region number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit i for byte lane i |
| rsp_done | output | 1 | One-clock pulse after the strobe ends |
| rsp_rdata | output | 16 | Read data from the last read |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 2 | Active-low write strobe per byte lane |
| mem_bls_n | output | 2 | Active-low byte selects |
| mem_addr | output | AW | External address |
| mem_dout | output | 16 | External write data |
| mem_doe | output | 1 | Output enable for mem_dout |
| mem_din | input | 16 | External read data |

## Verification
The checker watches pin-level rules on every clock. It confirms that a single CS is low at a time, that no strobe or output enable is active outside CS, that the read and write strobes never overlap, and that the address holds still while CS is low. It also confirms that done is a single pulse coinciding with the release of a strobe, and that ready stays low during an access. The phase lengths taken from each timing field, the early-read shortcut, the lane mapping of each bus-width mode and the returned read data depend on the configuration word. The directed scenarios show these by counting the clocks in each phase and comparing them with values computed from the word.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WAIT_W   = 7;
  localparam int CNT_W    = WAIT_W + 1;
  localparam int LANES    = 2;
  localparam int DATA_W   = 8 * LANES;
  localparam int WORD_W   = 32;
  localparam int NPHASE   = 7;

  // Phase order is the order in which an access walks through them.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ASET  = 3'd1,
    PH_CSSET = 3'd2,
    PH_STRB  = 3'd3,
    PH_CSHLD = 3'd4,
    PH_AHLD  = 3'd5,
    PH_FLOAT = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    LM_WIDE_ONE = 2'd0,
    LM_WIDE_TWO = 2'd1,
    LM_NARROW   = 2'd2
  } lane_mode_e;

  typedef struct packed {
    logic [1:0]        strobe_hold;
    logic [1:0]        strobe_setup;
    logic [1:0]        addr_gap;
    logic              early_read;
    lane_mode_e        lane_mode;
    logic [3:0]        float_clks;
    logic              wait_en;
    logic [WAIT_W-1:0] wait_cnt;
  } cs_timing_t;

  function automatic cs_timing_t unpack_word(input logic [WORD_W-1:0] w);
    cs_timing_t t;
    t.strobe_hold  = w[29:28];
    t.strobe_setup = w[25:24];
    t.addr_gap     = w[17:16];
    t.early_read   = w[15];
    t.float_clks   = w[11:8];
    t.wait_en      = w[7];
    t.wait_cnt     = w[6:0];
    if (w[14:13] == 2'd2)
      t.lane_mode = LM_NARROW;
    else if (w[12])
      t.lane_mode = LM_WIDE_TWO;
    else
      t.lane_mode = LM_WIDE_ONE;
    return t;
  endfunction
endpackage

// File: rtl/smc_cfg_select.sv
module smc_cfg_select
  import smc_pkg::*;
#(
  parameter int NCS   = 8,
  parameter int SEL_W = 3
) (
  input  logic [NCS*WORD_W-1:0] cfg_words,
  input  logic [SEL_W-1:0]      sel,
  output cs_timing_t            cfg
);
  cs_timing_t decoded [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign decoded[g] = unpack_word(cfg_words[g*WORD_W +: WORD_W]);
  end

  always_comb begin
    cfg = decoded[0];
    for (int i = 0; i < NCS; i++) begin
      if (SEL_W'(i) == sel) cfg = decoded[i];
    end
  end
endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_read,
  input  cs_timing_t cfg,
  output phase_e     phase_d,
  output logic       strobe_last
);
  phase_e                         phase_q;
  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic [NPHASE-1:0][CNT_W-1:0]   len;

  // Length in clocks of every phase for the current access; zero skips it.
  always_comb begin
    len           = '0;
    len[PH_ASET]  = CNT_W'(cfg.addr_gap);
    len[PH_CSSET] = (is_read && cfg.early_read) ? '0 : CNT_W'(cfg.strobe_setup);
    len[PH_STRB]  = cfg.wait_en ? (CNT_W'(cfg.wait_cnt) + CNT_W'(1)) : CNT_W'(1);
    len[PH_CSHLD] = CNT_W'(cfg.strobe_hold);
    len[PH_AHLD]  = CNT_W'(cfg.addr_gap);
    len[PH_FLOAT] = is_read ? CNT_W'(cfg.float_clks) : '0;
  end

  function automatic phase_e next_live(input phase_e from,
                                       input logic [NPHASE-1:0][CNT_W-1:0] l);
    phase_e r;
    logic   hit;
    r   = PH_IDLE;
    hit = 1'b0;
    for (int i = 1; i < NPHASE; i++) begin
      if (!hit && (i > int'(from)) && (l[i] != '0)) begin
        r   = phase_e'(3'(i));
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = next_live(PH_IDLE, len);
        cnt_d   = len[phase_d] - 1'b1;
      end
    end else if (cnt_q == '0) begin
      phase_d = next_live(phase_q, len);
      cnt_d   = (phase_d == PH_IDLE) ? '0 : (len[phase_d] - 1'b1);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign strobe_last = (phase_q == PH_STRB) && (cnt_q == '0);
endmodule

// File: rtl/smc_lane_map.sv
module smc_lane_map
  import smc_pkg::*;
(
  input  lane_mode_e       mode,
  input  logic [LANES-1:0] be,
  input  logic             is_write,
  input  logic             strobe_on,
  input  logic             cs_on,
  output logic [LANES-1:0] wr_n,
  output logic [LANES-1:0] bls_n
);
  logic wr_act;
  assign wr_act = is_write && strobe_on;

  always_comb begin
    wr_n  = '1;
    bls_n = '1;
    unique case (mode)
      LM_WIDE_TWO: begin
        if (wr_act) wr_n = ~be;
      end
      LM_NARROW: begin
        if (wr_act) wr_n = ~LANES'(1);
      end
      default: begin
        if (wr_act) wr_n = '0;
        if (cs_on)  bls_n = ~be;
      end
    endcase
  end
endmodule

// File: rtl/smc_cs_timing.sv
module smc_cs_timing
  import smc_pkg::*;
#(
  parameter int  NCS   = 8,
  parameter int  AW    = 24,
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCS*WORD_W-1:0] cfg_words,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [SEL_W-1:0]      req_cs,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [LANES-1:0]      req_be,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [NCS-1:0]        mem_cs_n,
  output logic                  mem_rd_n,
  output logic [LANES-1:0]      mem_wr_n,
  output logic [LANES-1:0]      mem_bls_n,
  output logic [AW-1:0]         mem_addr,
  output logic [DATA_W-1:0]     mem_dout,
  output logic                  mem_doe,
  input  logic [DATA_W-1:0]     mem_din
);
  logic             accept;
  cs_timing_t       req_cfg, lat_cfg, cur_cfg;
  logic [SEL_W-1:0] lat_cs, cur_cs;
  logic             lat_write, cur_write;
  logic [LANES-1:0] lat_be, cur_be;
  phase_e           phase_d;
  logic             strobe_last;
  logic             cs_on_d, strb_d;
  logic [NCS-1:0]   cs_sel_d;
  logic [LANES-1:0] wr_n_d, bls_n_d;

  assign accept = req_valid && req_ready;

  smc_cfg_select #(.NCS(NCS), .SEL_W(SEL_W)) u_sel (
    .cfg_words (cfg_words),
    .sel       (req_cs),
    .cfg       (req_cfg)
  );

  // Snapshot of the accepted request; used for the rest of the access.
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cfg   <= '0;
      lat_cs    <= '0;
      lat_write <= 1'b0;
      lat_be    <= '0;
    end else if (accept) begin
      lat_cfg   <= req_cfg;
      lat_cs    <= req_cs;
      lat_write <= req_write;
      lat_be    <= req_be;
    end
  end

  assign cur_cfg   = accept ? req_cfg   : lat_cfg;
  assign cur_cs    = accept ? req_cs    : lat_cs;
  assign cur_write = accept ? req_write : lat_write;
  assign cur_be    = accept ? req_be    : lat_be;

  smc_phase_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .is_read     (!cur_write),
    .cfg         (cur_cfg),
    .phase_d     (phase_d),
    .strobe_last (strobe_last)
  );

  assign cs_on_d = (phase_d == PH_CSSET) || (phase_d == PH_STRB) || (phase_d == PH_CSHLD);
  assign strb_d  = (phase_d == PH_STRB);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_sel_d[g] = cs_on_d && (cur_cs == SEL_W'(g));
  end

  smc_lane_map u_lane (
    .mode      (cur_cfg.lane_mode),
    .be        (cur_be),
    .is_write  (cur_write),
    .strobe_on (strb_d),
    .cs_on     (cs_on_d),
    .wr_n      (wr_n_d),
    .bls_n     (bls_n_d)
  );

  // All pins are flops loaded from the next-phase decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      mem_cs_n  <= '1;
      mem_rd_n  <= 1'b1;
      mem_wr_n  <= '1;
      mem_bls_n <= '1;
      mem_addr  <= '0;
      mem_dout  <= '0;
      mem_doe   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= (phase_d == PH_IDLE);
      mem_cs_n  <= ~cs_sel_d;
      mem_rd_n  <= !(strb_d && !cur_write);
      mem_wr_n  <= wr_n_d;
      mem_bls_n <= bls_n_d;
      mem_doe   <= cs_on_d && cur_write;
      rsp_done  <= strobe_last;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (strobe_last && !lat_write) begin
        if (lat_cfg.lane_mode == LM_NARROW)
          rsp_rdata <= DATA_W'(mem_din[7:0]);
        else
          rsp_rdata <= mem_din;
      end
    end
  end
endmodule

// File: rtl/smc_cs_timing_chk.sv
module smc_cs_timing_chk
  import smc_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [NCS-1:0]   mem_cs_n,
  input logic             mem_rd_n,
  input logic [LANES-1:0] mem_wr_n,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_doe
);
  logic any_cs;
  logic wr_any;
  assign any_cs = (mem_cs_n != '1);
  assign wr_any = (mem_wr_n != '1);

  // R2, R14: a single select at a time
  p_single_cs_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~mem_cs_n) <= 1);

  p_rd_inside_cs_r14: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> any_cs);

  p_wr_inside_cs_r14: assert property (@(posedge clk) disable iff (rst)
    wr_any |-> any_cs);

  p_no_rd_wr_overlap_r14: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && wr_any));

  // R3: address frozen while CS is low
  p_addr_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (any_cs && $past(any_cs)) |-> $stable(mem_addr));

  // R7: no ready during an access
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    any_cs |-> !req_ready);

  // R9: done is a single pulse aligned with the strobe release
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_done_rd_end_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> rsp_done);

  p_done_wr_end_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(&mem_wr_n) |-> rsp_done);

  // R13: output enable only inside CS and never with a read strobe
  p_doe_inside_cs_r13: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> any_cs);

  p_doe_not_read_r13: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> !mem_doe);
endmodule

bind smc_cs_timing smc_cs_timing_chk #(.NCS(NCS), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_cs_n  (mem_cs_n),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .mem_addr  (mem_addr),
  .mem_doe   (mem_doe)
);

// File: tb/smc_cs_timing_tb_top.sv
module smc_cs_timing_tb_top;
  localparam int NCS = 8;
  localparam int AW  = 24;
  localparam int SW  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCS*32-1:0] cfg_words = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SW-1:0]     req_cs = '0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [15:0]       req_wdata = '0;
  logic [1:0]        req_be = '0;
  logic              rsp_done;
  logic [15:0]       rsp_rdata;
  logic [NCS-1:0]    mem_cs_n;
  logic              mem_rd_n;
  logic [1:0]        mem_wr_n;
  logic [1:0]        mem_bls_n;
  logic [AW-1:0]     mem_addr;
  logic [15:0]       mem_dout;
  logic              mem_doe;
  logic [15:0]       mem_din;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  // Simple memory model: read data derived from the address.
  assign mem_din = mem_addr[15:0] ^ 16'h5A3C;

  smc_cs_timing #(.NCS(NCS), .AW(AW)) dut_i (
    .clk, .rst, .cfg_words, .req_valid, .req_ready, .req_cs, .req_write,
    .req_addr, .req_wdata, .req_be, .rsp_done, .rsp_rdata, .mem_cs_n,
    .mem_rd_n, .mem_wr_n, .mem_bls_n, .mem_addr, .mem_dout, .mem_doe, .mem_din
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input int hold, input int setup, input int agap,
                                      input bit early, input int dbw, input bit dual,
                                      input int flt, input bit wen, input int nws);
    logic [31:0] w;
    w        = '0;
    w[29:28] = 2'(hold);
    w[25:24] = 2'(setup);
    w[17:16] = 2'(agap);
    w[15]    = early;
    w[14:13] = 2'(dbw);
    w[12]    = dual;
    w[11:8]  = 4'(flt);
    w[7]     = wen;
    w[6:0]   = 7'(nws);
    return w;
  endfunction

  // One access; every phase length is counted at the pins.
  task automatic do_access(input int cs, input bit wr, input logic [AW-1:0] addr,
                           input logic [15:0] wd, input logic [1:0] be);
    logic [31:0] w;
    int exp_set, exp_strb, exp_post, agap, hold;
    bit narrow, dual;
    logic [1:0] exp_wr, exp_bls;
    int n_pre, n_set, n_strb, n_hold, n_post, stage, n_done, guard;
    bit done_ok, prev_str, cs_bad, lane_bad, bls_bad, doe_bad, strb;
    w        = cfg_words[cs*32 +: 32];
    agap     = int'(w[17:16]);
    hold     = int'(w[29:28]);
    narrow   = (w[14:13] == 2'd2);
    dual     = !narrow && w[12];
    exp_set  = (!wr && w[15]) ? 0 : int'(w[25:24]);
    exp_strb = w[7] ? int'(w[6:0]) + 1 : 1;
    exp_post = agap + (wr ? 0 : int'(w[11:8]));
    exp_wr   = narrow ? 2'b10 : (dual ? ~be : 2'b00);
    exp_bls  = (narrow || dual) ? 2'b11 : ~be;
    n_pre = 0; n_set = 0; n_strb = 0; n_hold = 0; n_post = 0; stage = 0;
    n_done = 0; guard = 0; done_ok = 1'b0; prev_str = 1'b0;
    cs_bad = 1'b0; lane_bad = 1'b0; bls_bad = 1'b0; doe_bad = 1'b0;

    while (!req_ready) @(negedge clk);
    req_cs = SW'(cs); req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (rsp_done) begin
        n_done++;
        if (prev_str) done_ok = 1'b1;
      end
      if (req_ready || guard > 600) break;
      guard++;
      strb = wr ? (mem_wr_n != 2'b11) : !mem_rd_n;
      if (mem_cs_n != '1) begin
        if (mem_cs_n != ~(NCS'(1) << cs)) cs_bad = 1'b1;
        if (mem_bls_n != exp_bls) bls_bad = 1'b1;
        if (wr && (!mem_doe || mem_dout != wd)) doe_bad = 1'b1;
      end else if (mem_bls_n != 2'b11) begin
        bls_bad = 1'b1;
      end
      if (mem_doe && (!wr || mem_cs_n == '1)) doe_bad = 1'b1;
      if (strb) begin
        stage = 2; n_strb++;
        if (wr && mem_wr_n != exp_wr) lane_bad = 1'b1;
        if (mem_addr != addr) cs_bad = 1'b1;
      end else if (stage >= 2) begin
        if (mem_cs_n != '1 && stage == 2) n_hold++;
        else if (mem_cs_n != '1 && stage == 3) n_hold++;
        else begin stage = 4; n_post++; end
        if (stage == 2) stage = 3;
      end else if (mem_cs_n != '1) begin
        stage = 1; n_set++;
      end else begin
        if (mem_addr != addr) cs_bad = 1'b1;
        n_pre++;
      end
      prev_str = strb;
      @(negedge clk);
    end
    chk("R7",  "access completes", longint'(guard <= 600), 1);
    chk("R2",  "select line and address", longint'(cs_bad), 0);
    chk("R3",  "address lead clocks", n_pre, agap);
    chk(w[15] ? "R8" : "R4", "CS lead clocks", n_set, exp_set);
    chk("R5",  "strobe clocks", n_strb, exp_strb);
    chk("R6",  "CS lag clocks", n_hold, hold);
    chk("R7",  "clocks from CS rise to ready", n_post, exp_post);
    chk("R9",  "done pulse count", n_done, 1);
    chk("R9",  "done follows strobe", longint'(done_ok), 1);
    chk(narrow ? "R12" : (dual ? "R11" : "R10"), "byte selects", longint'(bls_bad), 0);
    chk("R13", "output enable and data", longint'(doe_bad), 0);
    if (wr)
      chk(narrow ? "R12" : (dual ? "R11" : "R10"), "write strobe lanes", longint'(lane_bad), 0);
    else begin
      logic [15:0] m;
      m = addr[15:0] ^ 16'h5A3C;
      chk(narrow ? "R12" : "R9", "read data", rsp_rdata, narrow ? {8'h00, m[7:0]} : m);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cs_n", mem_cs_n, {NCS{1'b1}});
    chk("R1", "strobes", {mem_rd_n, mem_wr_n, mem_bls_n}, 5'b11111);
    chk("R1", "ready/done/doe", {req_ready, rsp_done, mem_doe}, 3'b100);
  endtask

  task automatic t_zero_timing;   // R5: wait count ignored when disabled
    do_access(0, 1'b0, 24'h000120, 16'h0, 2'b11);
    do_access(0, 1'b1, 24'h000122, 16'hBEEF, 2'b11);
  endtask

  task automatic t_basic_read;    // R3 R4 R5 R6 R7 R9
    do_access(3, 1'b0, 24'h3A0456, 16'h0, 2'b11);
  endtask

  task automatic t_basic_write;   // float not applied to writes (R7)
    do_access(5, 1'b1, 24'h500010, 16'h1234, 2'b11);
  endtask

  task automatic t_early_read;    // R8
    do_access(1, 1'b0, 24'h10ABCD, 16'h0, 2'b11);
    do_access(1, 1'b1, 24'h10ABCE, 16'hA5A5, 2'b11);
  endtask

  task automatic t_single_dev;    // R10
    do_access(2, 1'b1, 24'h200002, 16'h00C3, 2'b01);
    do_access(2, 1'b0, 24'h200004, 16'h0, 2'b10);
  endtask

  task automatic t_dual_dev;      // R11
    do_access(6, 1'b1, 24'h600100, 16'h7E00, 2'b10);
    do_access(6, 1'b1, 24'h600102, 16'h55AA, 2'b11);
    do_access(6, 1'b0, 24'h600104, 16'h0, 2'b11);
  endtask

  task automatic t_narrow;        // R12
    do_access(7, 1'b0, 24'h7000F1, 16'h0, 2'b11);
    do_access(7, 1'b1, 24'h7000F2, 16'h0099, 2'b10);
  endtask

  task automatic t_long;          // R5 R7 with long waits
    do_access(4, 1'b0, 24'h4FFFFE, 16'h0, 2'b11);
    do_access(4, 1'b1, 24'h400000, 16'hC0DE, 2'b11);
  endtask

  initial begin
    #(4 * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    cfg_words[0*32 +: 32] = mkw(0, 0, 0, 1'b0, 1, 1'b0, 0, 1'b0, 5);
    cfg_words[1*32 +: 32] = mkw(1, 3, 1, 1'b1, 1, 1'b0, 1, 1'b1, 2);
    cfg_words[2*32 +: 32] = mkw(1, 1, 0, 1'b0, 1, 1'b0, 0, 1'b1, 1);
    cfg_words[3*32 +: 32] = mkw(1, 2, 1, 1'b0, 1, 1'b0, 2, 1'b1, 3);
    cfg_words[4*32 +: 32] = mkw(3, 3, 3, 1'b0, 1, 1'b0, 15, 1'b1, 20);
    cfg_words[5*32 +: 32] = mkw(2, 1, 0, 1'b0, 1, 1'b0, 3, 1'b0, 0);
    cfg_words[6*32 +: 32] = mkw(1, 1, 1, 1'b0, 1, 1'b1, 0, 1'b1, 1);
    cfg_words[7*32 +: 32] = mkw(0, 1, 1, 1'b0, 2, 1'b0, 1, 1'b0, 0);
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_zero_timing();
    t_basic_read();
    t_basic_write();
    t_early_read();
    t_single_dev();
    t_dual_dev();
    t_narrow();
    t_long();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule